// File: doc/BRIEF.md
# Shuffle-linked 2x2 delta network

The block joins N = 2^n request sources to N destination ports through n stages of small arbitrating switches, N/2 switches per stage. Every source offers a request bit, an n-bit destination number and an information word in the same cycle. Before each stage the lines pass through a fixed perfect shuffle. Each switch then steers a request to its upper or lower output using one bit of the destination, with the most significant bit used first. So each source reaches each destination along exactly one path. When two requests at a switch want the same output, the one on the upper input wins. The loser is marked busy, and that mark travels straight back to its source.

Routing and busy return are combinational within one cycle. All results are taken into registers at the clock edge that closes the cycle: one busy flag per source, and one valid flag and one information word per destination. A source that sees busy may keep its request raised to try again in the next cycle; the network holds no memory of earlier cycles. Each switch output selects its driver through a three-valued lane selector: idle (no request routed), upper (the upper input routed) or lower (the lower input routed). The selector is recomputed every cycle from that cycle's requests alone and keeps no state between cycles.

Top module: `dnet_top`

## Requirements
- R1: While reset is low, all source busy flags, destination valid flags and destination information words read zero.
- R2: A request from source s with destination d that is not blocked sets valid on destination d one clock edge later, and that port carries the information word of s.
- R3: One clock edge after a cycle, the busy flag of a source is 1 exactly when it requested in that cycle and was not delivered. A source that did not request reads busy 0.
- R4: Routing order. Before every stage, line i moves to line (2i + floor(i / 2^(n-1))) mod N. Switch s of a stage takes lines 2s (upper) and 2s+1 (lower) and drives line 2s+b, where b is destination bit n-1-k in stage k. When both inputs choose the same b, the upper input wins. With n = 3, sources 0 and 4 both aimed at destination 0 leave source 4 busy.
- R5: If every requesting source i in a cycle asks for destination i, no source is busy.
- R6: The number of valid destinations plus the number of busy sources equals the number of requests in that cycle. The valid count never exceeds the number of distinct destinations requested.
- R7: A destination port whose valid flag is 0 shows an information word of zero.
- R8: When all N sources request the same destination, exactly that destination is valid and N-1 sources are busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | N | Request bit of each source |
| src_dst | input | N*n | Destination number of each source; source i uses bits [i*n +: n] |
| src_info | input | N*W | Information word of each source; source i uses bits [i*W +: W] |
| src_busy | output | N | Source was blocked in the previous cycle |
| dst_valid | output | N | Destination received a request in the previous cycle |
| dst_info | output | N*W | Information word delivered to each destination; port d uses bits [d*W +: W] |

## Verification
The properties assume that requests, destination numbers and information words are stable and known at each rising edge, and that reset is asynchronous while inputs are held at zero. The counting properties also rely on destination numbers being meaningful only where the request bit is set. The stimulus changes inputs only on falling edges, keeps all inputs low during reset, and draws every destination from the full n-bit range, so every value is legal. Random cycles mix sparse and dense request patterns. Directed cycles cover the identity pattern, one two-way clash at the first switch, and all sources aimed at a single port.

// File: rtl/dnet_pkg.sv
package dnet_pkg;

    // Driver chosen for one switch output in the current cycle
    typedef enum logic [1:0] {
        LANE_IDLE  = 2'd0,
        LANE_UPPER = 2'd1,
        LANE_LOWER = 2'd2
    } lane_src_e;

    // Perfect shuffle of 2^lg lines: rotate the line number left by one bit
    function automatic int dnet_shuffle(input int idx, input int lg);
        int mask;
        mask = (1 << lg) - 1;
        return ((idx << 1) | (idx >> (lg - 1))) & mask;
    endfunction

endpackage

// File: rtl/dnet_switch.sv
module dnet_switch
    import dnet_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int INFO_W = 8,
    parameter int SEL    = 0
) (
    input  logic [1:0]             in_req,
    input  logic [1:0][ADDR_W-1:0] in_dst,
    input  logic [1:0][INFO_W-1:0] in_info,
    output logic [1:0]             in_busy,
    output logic [1:0]             out_req,
    output logic [1:0][ADDR_W-1:0] out_dst,
    output logic [1:0][INFO_W-1:0] out_info,
    input  logic [1:0]             out_busy
);

    logic want_u;
    logic want_l;
    logic clash;
    logic take_l;

    always_comb begin
        want_u = in_dst[0][SEL];
        want_l = in_dst[1][SEL];
        clash  = in_req[0] & in_req[1] & (want_u == want_l);
        take_l = in_req[1] & ~clash;
    end

    // Busy goes back to an input if it lost here or its chosen output is blocked further on
    always_comb begin
        in_busy[0] = in_req[0] & out_busy[want_u];
        in_busy[1] = in_req[1] & (clash | out_busy[want_l]);
    end

    for (genvar p = 0; p < 2; p++) begin : g_port
        localparam logic PB = 1'(p);
        lane_src_e lane;

        always_comb begin
            if (in_req[0] && (want_u == PB)) begin
                lane = LANE_UPPER;
            end else if (take_l && (want_l == PB)) begin
                lane = LANE_LOWER;
            end else begin
                lane = LANE_IDLE;
            end
        end

        always_comb begin
            unique case (lane)
                LANE_UPPER: begin
                    out_req[p]  = 1'b1;
                    out_dst[p]  = in_dst[0];
                    out_info[p] = in_info[0];
                end
                LANE_LOWER: begin
                    out_req[p]  = 1'b1;
                    out_dst[p]  = in_dst[1];
                    out_info[p] = in_info[1];
                end
                default: begin
                    out_req[p]  = 1'b0;
                    out_dst[p]  = '0;
                    out_info[p] = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dnet_stage.sv
module dnet_stage
    import dnet_pkg::*;
#(
    parameter  int ADDR_W = 3,
    parameter  int INFO_W = 8,
    parameter  int STAGE  = 0,
    localparam int PORTS  = 1 << ADDR_W
) (
    input  logic [PORTS-1:0]             up_req,
    input  logic [PORTS-1:0][ADDR_W-1:0] up_dst,
    input  logic [PORTS-1:0][INFO_W-1:0] up_info,
    output logic [PORTS-1:0]             up_busy,
    output logic [PORTS-1:0]             dn_req,
    output logic [PORTS-1:0][ADDR_W-1:0] dn_dst,
    output logic [PORTS-1:0][INFO_W-1:0] dn_info,
    input  logic [PORTS-1:0]             dn_busy
);

    localparam int SWITCHES = PORTS / 2;
    localparam int SEL_BIT  = ADDR_W - 1 - STAGE;

    logic [PORTS-1:0]             sh_req;
    logic [PORTS-1:0][ADDR_W-1:0] sh_dst;
    logic [PORTS-1:0][INFO_W-1:0] sh_info;
    logic [PORTS-1:0]             sh_busy;

    // Passive shuffle links ahead of the switch column
    for (genvar i = 0; i < PORTS; i++) begin : g_link
        localparam int TO = dnet_shuffle(i, ADDR_W);
        assign sh_req[TO]  = up_req[i];
        assign sh_dst[TO]  = up_dst[i];
        assign sh_info[TO] = up_info[i];
        assign up_busy[i]  = sh_busy[TO];
    end

    for (genvar s = 0; s < SWITCHES; s++) begin : g_sw
        dnet_switch #(
            .ADDR_W (ADDR_W),
            .INFO_W (INFO_W),
            .SEL    (SEL_BIT)
        ) u_switch (
            .in_req   (sh_req[2*s +: 2]),
            .in_dst   (sh_dst[2*s +: 2]),
            .in_info  (sh_info[2*s +: 2]),
            .in_busy  (sh_busy[2*s +: 2]),
            .out_req  (dn_req[2*s +: 2]),
            .out_dst  (dn_dst[2*s +: 2]),
            .out_info (dn_info[2*s +: 2]),
            .out_busy (dn_busy[2*s +: 2])
        );
    end

endmodule

// File: rtl/dnet_capture.sv
module dnet_capture #(
    parameter  int ADDR_W = 3,
    parameter  int INFO_W = 8,
    localparam int PORTS  = 1 << ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PORTS-1:0]             end_req,
    input  logic [PORTS-1:0][INFO_W-1:0] end_info,
    input  logic [PORTS-1:0]             busy_d,
    output logic [PORTS-1:0]             busy_q,
    output logic [PORTS-1:0]             valid_q,
    output logic [PORTS-1:0][INFO_W-1:0] info_q
);

    logic [PORTS-1:0][INFO_W-1:0] info_d;

    always_comb begin
        for (int d = 0; d < PORTS; d++) begin
            info_d[d] = end_req[d] ? end_info[d] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= '0;
            valid_q <= '0;
            info_q  <= '0;
        end else begin
            busy_q  <= busy_d;
            valid_q <= end_req;
            info_q  <= info_d;
        end
    end

endmodule

// File: rtl/dnet_top.sv
module dnet_top #(
    parameter  int ADDR_W = 3,
    parameter  int INFO_W = 8,
    localparam int PORTS  = 1 << ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PORTS-1:0]          src_req,
    input  logic [PORTS*ADDR_W-1:0]   src_dst,
    input  logic [PORTS*INFO_W-1:0]   src_info,
    output logic [PORTS-1:0]          src_busy,
    output logic [PORTS-1:0]          dst_valid,
    output logic [PORTS*INFO_W-1:0]   dst_info
);

    // Line bundles between stages; index k feeds stage k
    logic [PORTS-1:0]             c_req  [ADDR_W+1];
    logic [PORTS-1:0][ADDR_W-1:0] c_dst  [ADDR_W+1];
    logic [PORTS-1:0][INFO_W-1:0] c_info [ADDR_W+1];
    logic [PORTS-1:0]             c_busy [ADDR_W+1];

    logic [PORTS-1:0][INFO_W-1:0] info_q;

    assign c_req[0]       = src_req;
    assign c_dst[0]       = src_dst;
    assign c_info[0]      = src_info;
    assign c_busy[ADDR_W] = '0;

    for (genvar k = 0; k < ADDR_W; k++) begin : g_stage
        dnet_stage #(
            .ADDR_W (ADDR_W),
            .INFO_W (INFO_W),
            .STAGE  (k)
        ) u_stage (
            .up_req  (c_req[k]),
            .up_dst  (c_dst[k]),
            .up_info (c_info[k]),
            .up_busy (c_busy[k]),
            .dn_req  (c_req[k+1]),
            .dn_dst  (c_dst[k+1]),
            .dn_info (c_info[k+1]),
            .dn_busy (c_busy[k+1])
        );
    end

    dnet_capture #(
        .ADDR_W (ADDR_W),
        .INFO_W (INFO_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .end_req  (c_req[ADDR_W]),
        .end_info (c_info[ADDR_W]),
        .busy_d   (c_busy[0]),
        .busy_q   (src_busy),
        .valid_q  (dst_valid),
        .info_q   (info_q)
    );

    assign dst_info = info_q;

endmodule

// File: rtl/dnet_checker.sv
module dnet_checker #(
    parameter  int ADDR_W = 3,
    parameter  int INFO_W = 8,
    localparam int PORTS  = 1 << ADDR_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PORTS-1:0]        src_req,
    input logic [PORTS*ADDR_W-1:0] src_dst,
    input logic [PORTS*INFO_W-1:0] src_info,
    input logic [PORTS-1:0]        src_busy,
    input logic [PORTS-1:0]        dst_valid,
    input logic [PORTS*INFO_W-1:0] dst_info
);

    logic ident_pattern;

    always_comb begin
        ident_pattern = 1'b1;
        for (int i = 0; i < PORTS; i++) begin
            if (src_req[i] && (src_dst[i*ADDR_W +: ADDR_W] != ADDR_W'(i))) begin
                ident_pattern = 1'b0;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (src_busy == '0 && dst_valid == '0 && dst_info == '0));

    // R5
    identity_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ident_pattern |=> (src_busy == '0));

    // R6
    grant_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($countones(dst_valid) + $countones(src_busy)) == $countones($past(src_req))));

    for (genvar i = 0; i < PORTS; i++) begin : g_port
        // R3
        idle_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !src_req[i] |=> !src_busy[i]);

        // R7
        empty_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dst_valid[i] |-> (dst_info[i*INFO_W +: INFO_W] == '0));
    end

endmodule

bind dnet_top dnet_checker #(
    .ADDR_W (ADDR_W),
    .INFO_W (INFO_W)
) u_dnet_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .src_dst   (src_dst),
    .src_info  (src_info),
    .src_busy  (src_busy),
    .dst_valid (dst_valid),
    .dst_info  (dst_info)
);

// File: tb/test_dnet_top.sv
`timescale 1ns/1ps
module test_dnet_top;

    localparam int A = 3;
    localparam int W = 8;
    localparam int N = 1 << A;

    logic           clk;
    logic           rst_n;
    logic [N-1:0]   src_req;
    logic [N*A-1:0] src_dst;
    logic [N*W-1:0] src_info;
    logic [N-1:0]   src_busy;
    logic [N-1:0]   dst_valid;
    logic [N*W-1:0] dst_info;

    logic [N-1:0]   req_v;
    logic [A-1:0]   dst_a  [N];
    logic [W-1:0]   info_a [N];
    logic [N-1:0]   exp_busy;
    logic [N-1:0]   exp_valid;
    logic [W-1:0]   exp_info [N];
    int             exp_distinct;

    int checks = 0;
    int errors = 0;

    dnet_top #(.ADDR_W(A), .INFO_W(W)) i_dnet_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .src_dst   (src_dst),
        .src_info  (src_info),
        .src_busy  (src_busy),
        .dst_valid (dst_valid),
        .dst_info  (dst_info)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    always_comb begin
        src_req = req_v;
        for (int i = 0; i < N; i++) begin
            src_dst[i*A +: A]  = dst_a[i];
            src_info[i*W +: W] = info_a[i];
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Network model built from the routing rules of R4
    task automatic model();
        int line [N];
        int nxt  [N];
        int sel, up, lo, o0, o1;
        for (int i = 0; i < N; i++) line[i] = req_v[i] ? i : -1;
        for (int k = 0; k < A; k++) begin
            sel = A - 1 - k;
            for (int i = 0; i < N; i++) nxt[((i << 1) | (i >> (A - 1))) & (N - 1)] = line[i];
            for (int s = 0; s < N / 2; s++) begin
                o0 = -1;
                o1 = -1;
                up = nxt[2*s];
                lo = nxt[2*s+1];
                if (up >= 0) begin
                    if (dst_a[up][sel]) o1 = up; else o0 = up;
                end
                if (lo >= 0) begin
                    if (dst_a[lo][sel]) begin
                        if (o1 < 0) o1 = lo;
                    end else begin
                        if (o0 < 0) o0 = lo;
                    end
                end
                line[2*s]   = o0;
                line[2*s+1] = o1;
            end
        end
        exp_busy  = req_v;
        exp_valid = '0;
        for (int d = 0; d < N; d++) begin
            if (line[d] >= 0) begin
                exp_valid[d]      = 1'b1;
                exp_info[d]       = info_a[line[d]];
                exp_busy[line[d]] = 1'b0;
            end else begin
                exp_info[d] = '0;
            end
        end
        exp_distinct = 0;
        for (int d = 0; d < N; d++) begin
            logic hit;
            hit = 1'b0;
            for (int i = 0; i < N; i++) if (req_v[i] && dst_a[i] == A'(d)) hit = 1'b1;
            if (hit) exp_distinct++;
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, compare at the next falling edge
    task automatic run_cycle(input string tag);
        model();
        @(negedge clk);
        checks++;
        if (src_busy !== exp_busy) begin
            errors++;
            $display("FAIL R3 %s: busy got %b expected %b", tag, src_busy, exp_busy);
        end
        checks++;
        if (dst_valid !== exp_valid) begin
            errors++;
            $display("FAIL R2 %s: valid got %b expected %b", tag, dst_valid, exp_valid);
        end
        for (int d = 0; d < N; d++) begin
            checks++;
            if (dst_info[d*W +: W] !== exp_info[d]) begin
                errors++;
                if (exp_valid[d])
                    $display("FAIL R2 %s: port %0d info got %h expected %h", tag, d, dst_info[d*W +: W], exp_info[d]);
                else
                    $display("FAIL R7 %s: port %0d info got %h expected %h", tag, d, dst_info[d*W +: W], exp_info[d]);
            end
        end
        checks++;
        if (($countones(dst_valid) + $countones(src_busy)) != $countones(req_v) ||
            $countones(dst_valid) > exp_distinct) begin
            errors++;
            $display("FAIL R6 %s: valid %0d busy %0d got, expected sum %0d and valid <= %0d",
                     tag, $countones(dst_valid), $countones(src_busy), $countones(req_v), exp_distinct);
        end
    endtask

    task automatic set_all(input logic [N-1:0] r, input int fixed_dst, input bit identity);
        req_v = r;
        for (int i = 0; i < N; i++) begin
            dst_a[i]  = identity ? A'(i) : A'(fixed_dst);
            info_a[i] = W'(8'h40 + i);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        set_all('0, 0, 1'b0);
        repeat (3) @(negedge clk);

        // R1 reset state
        checks++;
        if (src_busy !== '0 || dst_valid !== '0 || dst_info !== '0) begin
            errors++;
            $display("FAIL R1: busy %b valid %b info %h expected all zero", src_busy, dst_valid, dst_info);
        end
        rst_n = 1'b1;

        // R5 identity with every source active, then a sparse identity set
        set_all('1, 0, 1'b1);
        run_cycle("identity full");
        checks++;
        if (src_busy !== '0 || dst_valid !== '1) begin
            errors++;
            $display("FAIL R5: busy %b valid %b expected busy 0 valid all", src_busy, dst_valid);
        end
        set_all(8'b1010_0110, 0, 1'b1);
        run_cycle("identity sparse");
        checks++;
        if (src_busy !== '0) begin
            errors++;
            $display("FAIL R5 sparse: busy got %b expected 0", src_busy);
        end

        // R4 clash at the first switch: sources 0 and 4 meet on switch 0, upper wins
        set_all(8'b0001_0001, 0, 1'b0);
        run_cycle("clash 0/4");
        checks++;
        if (src_busy !== 8'b0001_0000 || dst_valid !== 8'b0000_0001 || dst_info[W-1:0] !== 8'h40) begin
            errors++;
            $display("FAIL R4: busy %b valid %b info %h expected busy 00010000 valid 00000001 info 40",
                     src_busy, dst_valid, dst_info[W-1:0]);
        end

        // R8 every source to destination 5
        set_all('1, 5, 1'b0);
        run_cycle("all to 5");
        checks++;
        if (dst_valid !== 8'b0010_0000 || $countones(src_busy) != N - 1) begin
            errors++;
            $display("FAIL R8: valid %b busy count %0d expected valid 00100000 busy count %0d",
                     dst_valid, $countones(src_busy), N - 1);
        end

        // R7 no requests: all ports empty
        set_all('0, 3, 1'b0);
        run_cycle("idle");

        // R2 R3 R6 random patterns with varying density
        for (int c = 0; c < 400; c++) begin
            int dens;
            dens = (c % 4) + 1;
            for (int i = 0; i < N; i++) begin
                req_v[i]  = (($urandom % 5) < dens);
                dst_a[i]  = A'($urandom);
                info_a[i] = W'({($urandom % 32), 3'(i)});
            end
            run_cycle("random");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule